// File: doc/BRIEF.md
# Pin-Loaded Mailbox Byte With Host Interrupt

This block lets add-on logic post one byte to the host without a register write. The top byte of the fourth incoming mailbox is loaded from eight external data pins. A ninth pin acts as a load strobe. That strobe idles high. When the add-on pulls it low and then releases it high, the block captures the data pins on the return to high. It then raises the host interrupt, provided the incoming-mailbox interrupt is enabled and its slot selector points at this byte.

After a capture, the block locks out further strobes until the host issues a clear pulse and the interrupt line drops. A static configuration input says whether the pins carry this function. When it is low, the pins belong to a byte-wide boot device. In that case the strobe can never raise an interrupt and the host always reads the byte as zero.

The strobe and data pins are asynchronous. Both pass through a synchroniser chain of the same depth, so the data stays aligned with the strobe edge. The host side is reduced to a combinational read port and a one-cycle clear input.

Top module: `strobe_mbx_byte`

## Requirements
- R1: After reset `irq` is 0, `rd_data` is 0 and the latched byte is 0.
- R2: A strobe capture is accepted only when all of these hold: `cfg_pin_mode`=1, `irq_en`=1, `irq_sel_box`=3 (the fourth mailbox, zero-based) and `irq_sel_byte`=3 (the top byte). When accepted, a low-to-high transition of `ext_stb` latches `ext_data` and sets `irq`. The new byte and `irq` are visible after the third rising clock edge that follows the strobe's rise.
- R3: While `cfg_pin_mode`=1, `rd_data` shows the latched byte.
- R4: While `cfg_pin_mode`=0, `rd_data` reads 0 and strobe edges neither set `irq` nor change the latched byte. The latched byte reappears when the mode returns to 1.
- R5: A strobe edge arriving while `irq_en`=0, or while the selector codes differ from box 3 / byte 3, leaves `irq` low and the latched byte unchanged.
- R6: While `irq`=1, further strobe edges do not change the latched byte.
- R7: `irq` stays 1 until a cycle with `irq_clr`=1, and it is 0 after that clock edge.
- R8: A strobe edge accepted in the same cycle as a clear that drops `irq` is ignored. `irq` ends at 0 and the byte is unchanged.
- R9: The strobe held steadily high, or held steadily low, never sets `irq`. Only the low-to-high transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pin_mode | input | 1 | 1: pins carry the strobe function; 0: byte-wide boot device fitted |
| irq_en | input | 1 | Incoming-mailbox interrupt enable |
| irq_sel_box | input | 2 | Mailbox selected for the interrupt (zero-based) |
| irq_sel_byte | input | 2 | Byte selected within that mailbox |
| ext_stb | input | 1 | Asynchronous load strobe, idles high |
| ext_data | input | 8 | Asynchronous data pins |
| irq_clr | input | 1 | One-cycle clear of the interrupt from the host |
| rd_data | output | 8 | Host read value of the mailbox byte |
| irq | output | 1 | Host interrupt request |

## Verification
The host clear and a strobe rising edge can fall in the same clock cycle. The bench provokes this by asserting `irq_clr` in the cycle in which the synchronised strobe edge is detected, both while `irq` is high and while it is low. With `irq` high, it expects the clear to win: `irq` ends low and `rd_data` keeps the old byte. With `irq` low, it expects the new strobe to be accepted. The random phase mixes such collisions with mode, enable and selector changes and compares every result against a bench model.

// File: rtl/strobe_mbx_pkg.sv
package strobe_mbx_pkg;
   localparam int unsigned DEF_DATA_W    = 8;
   localparam int unsigned DEF_SEL_W     = 2;
   localparam int unsigned DEF_SYNC_STGS = 2;

   // True when the interrupt selector points at the pin-loaded slot.
   function automatic logic slot_hit(input logic [DEF_SEL_W-1:0] box,
                                     input logic [DEF_SEL_W-1:0] byt,
                                     input logic [DEF_SEL_W-1:0] ref_box,
                                     input logic [DEF_SEL_W-1:0] ref_byt);
      return (box == ref_box) && (byt == ref_byt);
   endfunction
endpackage

// File: rtl/strobe_mbx_sync.sv
module strobe_mbx_sync #(
   parameter int unsigned   W      = 8,
   parameter int unsigned   STAGES = 2,
   parameter logic [W-1:0]  RST_V  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("strobe_mbx_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stg
         logic [W-1:0] r;
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_V;
               else        r <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) r <= RST_V;
               else        r <= g_stg[i-1].r;
            end
         end
      end
   endgenerate

   assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/strobe_mbx_rise.sv
module strobe_mbx_rise #(
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= IDLE_LVL;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/strobe_mbx_capture.sv
module strobe_mbx_capture #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rise,
   input  logic         armed,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic [W-1:0] held,
   output logic         irq_q
);
   logic accept;

   // Lockout: a raised interrupt blocks any new capture, including one
   // in the very cycle the clear arrives.
   assign accept = rise & armed & ~irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held  <= '0;
         irq_q <= 1'b0;
      end else begin
         if (accept) held <= din;
         irq_q <= accept | (irq_q & ~clr);
      end
   end
endmodule

// File: rtl/strobe_mbx_byte.sv
module strobe_mbx_byte
   import strobe_mbx_pkg::*;
#(
   parameter int unsigned DATA_W    = DEF_DATA_W,
   parameter int unsigned SEL_W     = DEF_SEL_W,
   parameter int unsigned SYNC_STGS = DEF_SYNC_STGS,
   parameter int unsigned SLOT_BOX  = 3,
   parameter int unsigned SLOT_BYTE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_pin_mode,
   input  logic              irq_en,
   input  logic [SEL_W-1:0]  irq_sel_box,
   input  logic [SEL_W-1:0]  irq_sel_byte,
   input  logic              ext_stb,
   input  logic [DATA_W-1:0] ext_data,
   input  logic              irq_clr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int unsigned BUS_W = DATA_W + 1;
   localparam logic [SEL_W-1:0] REF_BOX = SEL_W'(SLOT_BOX);
   localparam logic [SEL_W-1:0] REF_BYT = SEL_W'(SLOT_BYTE);
   localparam logic [BUS_W-1:0] SYNC_RST = {1'b1, {DATA_W{1'b0}}};

   generate
      if (SEL_W != DEF_SEL_W) begin : g_bad_sel
         $error("strobe_mbx_byte: SEL_W must match the package selector width");
      end
      if (SLOT_BOX >= (1 << SEL_W) || SLOT_BYTE >= (1 << SEL_W)) begin : g_bad_slot
         $error("strobe_mbx_byte: slot index out of selector range");
      end
   endgenerate

   logic [BUS_W-1:0]  sync_q;
   logic              stb_s;
   logic [DATA_W-1:0] data_s;
   logic              stb_rise;
   logic              armed;
   logic [DATA_W-1:0] held;

   // Strobe and data share one chain so they stay cycle aligned.
   strobe_mbx_sync #(.W(BUS_W), .STAGES(SYNC_STGS), .RST_V(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ext_stb, ext_data}),
      .q     (sync_q)
   );
   assign stb_s  = sync_q[DATA_W];
   assign data_s = sync_q[DATA_W-1:0];

   strobe_mbx_rise #(.IDLE_LVL(1'b1)) u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (stb_s),
      .rise  (stb_rise)
   );

   assign armed = cfg_pin_mode & irq_en &
                  slot_hit(irq_sel_box, irq_sel_byte, REF_BOX, REF_BYT);

   strobe_mbx_capture #(.W(DATA_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .rise  (stb_rise),
      .armed (armed),
      .clr   (irq_clr),
      .din   (data_s),
      .held  (held),
      .irq_q (irq)
   );

   assign rd_data = cfg_pin_mode ? held : '0;
endmodule

// File: rtl/strobe_mbx_byte_chk.sv
module strobe_mbx_byte_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SEL_W     = 2,
   parameter int unsigned SLOT_BOX  = 3,
   parameter int unsigned SLOT_BYTE = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_pin_mode,
   input logic              irq_en,
   input logic [SEL_W-1:0]  irq_sel_box,
   input logic [SEL_W-1:0]  irq_sel_byte,
   input logic              irq_clr,
   input logic [DATA_W-1:0] rd_data,
   input logic              irq
);
   logic sel_ok;
   assign sel_ok = (irq_sel_box == SEL_W'(SLOT_BOX)) && (irq_sel_byte == SEL_W'(SLOT_BYTE));

   a_r4_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_pin_mode |-> rd_data == '0);

   a_r4_no_irq_boot: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pin_mode && !irq) |=> !irq);

   a_r5_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (!(irq_en && sel_ok) && !irq) |=> !irq);

   a_r2_rise_armed: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(cfg_pin_mode && irq_en && sel_ok));

   a_r6_locked_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && cfg_pin_mode) |=> (!cfg_pin_mode || $stable(rd_data)));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && irq_clr) |=> !irq);
endmodule

bind strobe_mbx_byte strobe_mbx_byte_chk #(
   .DATA_W(DATA_W), .SEL_W(SEL_W), .SLOT_BOX(SLOT_BOX), .SLOT_BYTE(SLOT_BYTE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_pin_mode (cfg_pin_mode),
   .irq_en       (irq_en),
   .irq_sel_box  (irq_sel_box),
   .irq_sel_byte (irq_sel_byte),
   .irq_clr      (irq_clr),
   .rd_data      (rd_data),
   .irq          (irq)
);

// File: tb/strobe_mbx_byte_tb.sv
module strobe_mbx_byte_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_pin_mode = 1'b1;
   logic       irq_en = 1'b1;
   logic [1:0] irq_sel_box = 2'd3;
   logic [1:0] irq_sel_byte = 2'd3;
   logic       ext_stb = 1'b1;
   logic [7:0] ext_data = 8'h00;
   logic       irq_clr = 1'b0;
   logic [7:0] rd_data;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   logic [7:0] exp_byte = 8'h00;
   logic       exp_irq  = 1'b0;

   always #10 clk = ~clk;

   strobe_mbx_byte u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_pin_mode(cfg_pin_mode), .irq_en(irq_en),
      .irq_sel_box(irq_sel_box), .irq_sel_byte(irq_sel_byte), .ext_stb(ext_stb),
      .ext_data(ext_data), .irq_clr(irq_clr), .rd_data(rd_data), .irq(irq)
   );

   function automatic logic is_armed();
      return cfg_pin_mode && irq_en && irq_sel_box == 2'd3 && irq_sel_byte == 2'd3;
   endfunction

   function automatic logic [7:0] exp_read();
      return cfg_pin_mode ? exp_byte : 8'h00;
   endfunction

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " irq"}, {7'd0, irq}, {7'd0, exp_irq});
      check({tag, " rd_data"}, rd_data, exp_read());
   endtask

   // Low pulse on the strobe; optional host clear in the detect cycle.
   task automatic pulse(input logic [7:0] d, input logic with_clr);
      logic acc;
      @(negedge clk);
      ext_data = d;
      ext_stb  = 1'b0;
      repeat (3) @(negedge clk);
      ext_stb = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if (with_clr) irq_clr = 1'b1;
      acc = is_armed() && !exp_irq;
      @(negedge clk);
      irq_clr = 1'b0;
      if (acc) exp_byte = d;
      exp_irq = acc | (exp_irq & ~with_clr);
   endtask

   task automatic host_clear();
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      exp_irq = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      check_all("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 after reset");

      // R9: steady high with data moving, then steady low
      repeat (10) begin @(negedge clk); ext_data = ext_data + 8'h11; end
      check_all("R9 steady high");
      ext_stb = 1'b0;
      repeat (10) @(negedge clk);
      check_all("R9 steady low");
      ext_stb = 1'b1;
      @(negedge clk);
      ext_data = 8'h00;
      repeat (4) @(negedge clk);
      host_clear();
      exp_byte = rd_data;   // a capture may have occurred on the release
      check_all("R9 resync");

      // R2 / R3: armed capture
      pulse(8'hA5, 1'b0);
      check_all("R2 R3 capture");

      // R6: strobe while locked
      pulse(8'h3C, 1'b0);
      check_all("R6 lockout");

      // R7: interrupt holds, then clears
      repeat (20) @(negedge clk);
      check_all("R7 hold");
      host_clear();
      check_all("R7 clear");

      // R8: clear and strobe edge collide while irq high
      pulse(8'h5A, 1'b0);
      check_all("R8 setup");
      pulse(8'h77, 1'b1);
      check_all("R8 clear wins");
      // collision with irq low: new strobe accepted
      pulse(8'h19, 1'b1);
      check_all("R8 set when idle");
      host_clear();

      // R5: disabled or other slot selected
      irq_en = 1'b0;       pulse(8'hE1, 1'b0); check_all("R5 disabled");
      irq_en = 1'b1; irq_sel_box = 2'd2;  pulse(8'hE2, 1'b0); check_all("R5 box mismatch");
      irq_sel_box = 2'd3; irq_sel_byte = 2'd1; pulse(8'hE3, 1'b0); check_all("R5 byte mismatch");
      irq_sel_byte = 2'd3;

      // R4: boot-device configuration
      @(negedge clk); cfg_pin_mode = 1'b0; #1;
      check_all("R4 zero read");
      pulse(8'h99, 1'b0);
      check_all("R4 strobe ignored");
      @(negedge clk); cfg_pin_mode = 1'b1; #1;
      check_all("R4 byte kept");

      // random phase
      for (int n = 0; n < 300; n++) begin
         int op;
         op = $urandom % 6;
         if (op <= 2) begin
            irq_en       = ($urandom % 5) != 0;
            irq_sel_box  = (($urandom % 4) != 0) ? 2'd3 : 2'($urandom);
            irq_sel_byte = (($urandom % 4) != 0) ? 2'd3 : 2'($urandom);
            pulse(8'($urandom), ($urandom % 6) == 0);
            check_all("R2 R5 R6 R8 random strobe");
         end else if (op == 3) begin
            host_clear();
            check_all("R7 random clear");
         end else if (op == 4) begin
            @(negedge clk);
            cfg_pin_mode = ($urandom % 4) != 0;
            #1;
            check_all("R3 R4 random mode");
         end else begin
            repeat (1 + $urandom % 5) @(negedge clk);
            check_all("R7 random idle");
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule